// File: doc/BRIEF.md
# Vicinity Reader Command Decoder

This block sits in the receive path of an emulated vicinity card. It takes the reader's field after demodulation and thresholding as one sample per clock (1 means carrier present, 0 means the reader is modulating). It finds the start-of-frame, works out from the shape of that start-of-frame whether the reader is using 1-out-of-4 or 1-out-of-256 pulse-position coding, turns the pulse positions that follow into command bytes, and stops at the end-of-frame.

Each decoded byte is delivered with a one-cycle strobe. At the end of a command the block pulses a completion flag with the byte count and the detected coding. It also gives two timestamps from a free-running tick counter: the time of the end-of-frame, and the start-of-frame time worked back from the end-of-frame time and the frame length. A response scheduler downstream can use these timestamps. A command longer than the configured limit is flagged and thrown away.

Top module: `vcd_cmd_decoder`

## Requirements
- R1: After reset the decoder ignores the line until it has seen at least one high sample. A line held low from reset yields no byte, no frame and no overflow.
- R2: The first falling edge sets the position count to 1. The count rises by one on every later sample. A rising edge reached at a count below 4 abandons the start-of-frame, and the decoder waits for a new falling edge. A rising edge at count 4 or more is accepted.
- R3: The second falling edge sets the coding. A count of 20 to 22 selects 1-out-of-4 (codingMode 0). A count of 28 to 29 selects 1-out-of-256 (codingMode 1). Any other count below 28 fully resets the decoder, so carrier must be seen again. A high level that reaches count 30 abandons the start-of-frame.
- R4: The next rising edge must come at count 32 or later for 1-out-of-256, or at count 24 or later for 1-out-of-4; an earlier edge abandons the start-of-frame. In 1-out-of-256 the data starts on the sample after that edge. In 1-out-of-4 the line must then stay high for 9 samples, counting the edge sample, and data starts on the sample after that. A low sample in this tail fully resets the decoder.
- R5: Each data slot is 8 samples long. Let A be the number of high samples in the first four and B the number in the last four. A slot with A ≤ 1 and B ≥ 3 is the end-of-frame. A slot with A ≥ 3 and B ≤ 1 is a pulse. Any other slot is ignored.
- R6: In 1-out-of-4 coding each byte takes 16 slots, in four groups of four. A pulse in slot k (0..3) of a group shifts the value k in as two bits at the top of the byte. The first group therefore ends up as bits 1:0.
- R7: In 1-out-of-256 coding each byte takes 256 slots. The index of the pulsed slot is the byte value, and the byte is delivered after slot 255.
- R8: At the end-of-frame, frameDone pulses for one cycle with frameLen equal to the number of bytes delivered. This happens only if at least one byte was received and the frame did not overflow.
- R9: The tick counter is 0 in the first cycle after reset is released and counts every clock. eofTime equals the counter value in the cycle in which frameDone is first seen, minus one. sofTime equals eofTime − frameLen × (128 in 1-out-of-4, 2048 in 1-out-of-256) − 48.
- R10: A byte that would exceed MaxLen (default 8) is not delivered. overflow pulses once instead, and that frame never raises frameDone. The next start-of-frame clears this condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one line sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rxSample | input | 1 | Thresholded reader field, 1 = carrier present |
| byteValid | output | 1 | One-cycle strobe for byteData |
| byteData | output | 8 | Decoded command byte |
| frameDone | output | 1 | One-cycle pulse at a reported end-of-frame |
| frameLen | output | 4 | Byte count of the last reported frame |
| overflow | output | 1 | One-cycle pulse when a frame exceeds MaxLen |
| codingMode | output | 1 | 0 = 1-out-of-4, 1 = 1-out-of-256 |
| eofTime | output | 32 | Tick count at the end-of-frame |
| sofTime | output | 32 | Start-of-frame tick count derived from eofTime |

## Verification
The assertions assume that the line is sampled exactly once per clock. They also assume that nothing drives rxSample between clock edges except at sample boundaries, so every edge count refers to whole samples. The stimulus changes the line only on the falling clock edge, one sample at a time. Every frame it builds has whole 8-sample slots and exactly one pulse per group or per byte, apart from the deliberately malformed start-of-frame and overflow cases. After each malformed start-of-frame the stimulus sends at least 40 high samples, so the decoder is known to be re-armed before the next valid frame.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

  // start-of-frame edge windows, in samples counted from the first falling edge
  localparam int RISE1_MIN    = 4;
  localparam int FALL4_LO     = 20;
  localparam int FALL4_HI     = 22;
  localparam int FALL256_LO   = 28;
  localparam int FALL256_HI   = 29;
  localparam int RISE4_MIN    = 24;
  localparam int RISE256_MIN  = 32;
  localparam int TAIL4_LEN    = 9;

  // durations used to derive the start-of-frame time
  localparam int SOF_TICKS    = 32;
  localparam int EOF_TICKS    = 16;
  localparam int BYTE4_SHIFT  = 7;   // 128 ticks per byte
  localparam int BYTE256_SHIFT = 11; // 2048 ticks per byte

  typedef enum logic [2:0] {
    ST_WAIT_CARRIER,
    ST_ARMED,
    ST_SOF_LOW1,
    ST_SOF_HIGH,
    ST_SOF_LOW2,
    ST_SOF_TAIL,
    ST_DATA
  } decState_e;

  typedef struct packed {
    logic clrFrame;  // a new frame's data phase begins next sample
    logic dataEn;    // current sample belongs to a data slot
    logic mode256;   // 1-out-of-256 coding selected
  } dpCtrl_t;

endpackage

// File: rtl/vcd_in_sync.sv
module vcd_in_sync #(
  parameter int Stages = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [Stages-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[Stages-2:0], din};
  end

  assign dout = chain[Stages-1];
endmodule

// File: rtl/vcd_frame_ctrl.sv
module vcd_frame_ctrl
  import vcd_pkg::*;
#(
  parameter int Rise1Min   = RISE1_MIN,
  parameter int Fall4Lo    = FALL4_LO,
  parameter int Fall4Hi    = FALL4_HI,
  parameter int Fall256Lo  = FALL256_LO,
  parameter int Fall256Hi  = FALL256_HI,
  parameter int Rise4Min   = RISE4_MIN,
  parameter int Rise256Min = RISE256_MIN,
  parameter int Tail4Len   = TAIL4_LEN
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    bitIn,
  input  logic    eofHit,
  output dpCtrl_t ctrl
);
  localparam int PosW = $clog2(Rise256Min + 2);
  localparam logic [PosW-1:0] R1P   = PosW'(Rise1Min);
  localparam logic [PosW-1:0] F4LoP = PosW'(Fall4Lo);
  localparam logic [PosW-1:0] F4HiP = PosW'(Fall4Hi);
  localparam logic [PosW-1:0] F8LoP = PosW'(Fall256Lo);
  localparam logic [PosW-1:0] F8HiP = PosW'(Fall256Hi);
  localparam logic [PosW-1:0] R4P   = PosW'(Rise4Min);
  localparam logic [PosW-1:0] R8P   = PosW'(Rise256Min);
  localparam logic [PosW-1:0] TailP = PosW'(Tail4Len);

  decState_e       state, stateNxt;
  logic [PosW-1:0] pos, posNxt, posInc;
  logic            modeReg, modeNxt, startData;

  assign posInc = (pos == '1) ? pos : pos + 1'b1;

  always_comb begin
    stateNxt  = state;
    posNxt    = pos;
    modeNxt   = modeReg;
    startData = 1'b0;
    unique case (state)
      ST_WAIT_CARRIER: if (bitIn) stateNxt = ST_ARMED;
      ST_ARMED: begin
        if (!bitIn) begin
          posNxt   = PosW'(1);
          stateNxt = ST_SOF_LOW1;
        end
      end
      ST_SOF_LOW1: begin
        posNxt = posInc;
        if (bitIn) stateNxt = (posInc < R1P) ? ST_ARMED : ST_SOF_HIGH;
      end
      ST_SOF_HIGH: begin
        posNxt = posInc;
        if (!bitIn) begin
          if (posInc >= F4LoP && posInc <= F4HiP) begin
            modeNxt  = 1'b0;
            stateNxt = ST_SOF_LOW2;
          end else if (posInc < F8LoP) begin
            stateNxt = ST_WAIT_CARRIER;
          end else begin
            modeNxt  = 1'b1;
            stateNxt = ST_SOF_LOW2;
          end
        end else if (posInc > F8HiP) begin
          stateNxt = ST_ARMED;
        end
      end
      ST_SOF_LOW2: begin
        posNxt = posInc;
        if (bitIn) begin
          if (modeReg) begin
            if (posInc < R8P) stateNxt = ST_ARMED;
            else begin
              stateNxt  = ST_DATA;
              startData = 1'b1;
            end
          end else begin
            if (posInc < R4P) stateNxt = ST_ARMED;
            else begin
              posNxt   = PosW'(1);
              stateNxt = ST_SOF_TAIL;
            end
          end
        end
      end
      ST_SOF_TAIL: begin
        posNxt = posInc;
        if (!bitIn) stateNxt = ST_WAIT_CARRIER;
        else if (posInc == TailP) begin
          stateNxt  = ST_DATA;
          startData = 1'b1;
        end
      end
      ST_DATA: if (eofHit) stateNxt = ST_WAIT_CARRIER;
      default: stateNxt = ST_WAIT_CARRIER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_WAIT_CARRIER;
      pos     <= '0;
      modeReg <= 1'b0;
    end else begin
      state   <= stateNxt;
      pos     <= posNxt;
      modeReg <= modeNxt;
    end
  end

  assign ctrl.clrFrame = startData;
  assign ctrl.dataEn   = (state == ST_DATA);
  assign ctrl.mode256  = modeReg;

  // R1: no progress until carrier has been seen
  p_wait_carrier_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_CARRIER && !bitIn) |=> state == ST_WAIT_CARRIER);

  // R2: early rising edge abandons the start-of-frame
  p_early_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SOF_LOW1 && bitIn && pos < R1P - 1'b1) |=> state == ST_ARMED);

  // R3: coding is frozen while data slots are being decoded
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && !eofHit) |=> (state == ST_DATA && $stable(modeReg)));

  // R4: a low sample inside the 1-out-of-4 tail drops the carrier lock
  p_tail_break_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SOF_TAIL && !bitIn) |=> state == ST_WAIT_CARRIER);
endmodule

// File: rtl/vcd_slot_datapath.sv
module vcd_slot_datapath
  import vcd_pkg::*;
#(
  parameter int MaxLen = 8,
  parameter int TsW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitIn,
  input  dpCtrl_t           ctrl,
  output logic              eofHit,
  output logic              byteValid,
  output logic [7:0]        byteData,
  output logic              frameDone,
  output logic [$clog2(MaxLen+1)-1:0] frameLen,
  output logic              overflow,
  output logic [TsW-1:0]    eofTime,
  output logic [TsW-1:0]    sofTime
);
  localparam int LenW = $clog2(MaxLen + 1);
  localparam logic [LenW-1:0] MaxLenP = LenW'(MaxLen);
  localparam logic [TsW-1:0]  FrameOverhead = TsW'(SOF_TICKS + EOF_TICKS);

  logic [2:0]      sampIdx, sumA, sumB, sumANxt, sumBNxt;
  logic [7:0]      slotCnt, shReg, shNxt;
  logic [LenW-1:0] byteCnt;
  logic            dropFlag;
  logic [TsW-1:0]  tickCnt, bodyTicks;
  logic            lastSamp, isEofSlot, isMark, byteEnd;

  assign sumANxt  = sampIdx[2] ? sumA : sumA + {2'b00, bitIn};
  assign sumBNxt  = sampIdx[2] ? sumB + {2'b00, bitIn} : sumB;
  assign lastSamp = (sampIdx == 3'd7);
  assign isEofSlot = (sumANxt <= 3'd1) && (sumBNxt >= 3'd3);
  assign isMark    = (sumANxt >= 3'd3) && (sumBNxt <= 3'd1);
  assign eofHit    = ctrl.dataEn && lastSamp && isEofSlot;
  assign byteEnd   = ctrl.mode256 ? (slotCnt == 8'hFF) : (slotCnt[3:0] == 4'hF);

  always_comb begin
    shNxt = shReg;
    if (isMark) shNxt = ctrl.mode256 ? slotCnt : {slotCnt[1:0], shReg[7:2]};
  end

  assign bodyTicks = ctrl.mode256 ? (TsW'(byteCnt) << BYTE256_SHIFT)
                                  : (TsW'(byteCnt) << BYTE4_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt   <= '0;
      sampIdx   <= '0;
      sumA      <= '0;
      sumB      <= '0;
      slotCnt   <= '0;
      shReg     <= '0;
      byteCnt   <= '0;
      dropFlag  <= 1'b0;
      byteValid <= 1'b0;
      byteData  <= '0;
      frameDone <= 1'b0;
      frameLen  <= '0;
      overflow  <= 1'b0;
      eofTime   <= '0;
      sofTime   <= '0;
    end else begin
      tickCnt   <= tickCnt + 1'b1;
      byteValid <= 1'b0;
      frameDone <= 1'b0;
      overflow  <= 1'b0;
      if (ctrl.clrFrame) begin
        sampIdx  <= '0;
        sumA     <= '0;
        sumB     <= '0;
        slotCnt  <= '0;
        shReg    <= '0;
        byteCnt  <= '0;
        dropFlag <= 1'b0;
      end else if (ctrl.dataEn) begin
        sampIdx <= sampIdx + 1'b1;
        if (!lastSamp) begin
          sumA <= sumANxt;
          sumB <= sumBNxt;
        end else begin
          sumA <= '0;
          sumB <= '0;
          if (isEofSlot) begin
            frameDone <= (byteCnt != '0) && !dropFlag;
            frameLen  <= byteCnt;
            eofTime   <= tickCnt;
            sofTime   <= tickCnt - bodyTicks - FrameOverhead;
          end else begin
            shReg   <= shNxt;
            slotCnt <= byteEnd ? 8'h00 : slotCnt + 1'b1;
            if (byteEnd) begin
              if (byteCnt == MaxLenP) begin
                overflow <= !dropFlag;
                dropFlag <= 1'b1;
              end else begin
                byteValid <= 1'b1;
                byteData  <= shNxt;
                byteCnt   <= byteCnt + 1'b1;
              end
            end
          end
        end
      end
    end
  end

  // R8: a reported frame always carries at least one byte
  p_frame_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> frameLen != '0);

  // R10: a reported frame never exceeds the length limit
  p_len_bound_r10: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> frameLen <= MaxLenP);

  // R5: the end-of-frame slot never also completes a byte
  p_eof_not_byte_r5: assert property (@(posedge clk) disable iff (rst)
    byteValid |-> !frameDone);

  // R10: overflow and byte delivery are exclusive
  p_ovf_excl_r10: assert property (@(posedge clk) disable iff (rst)
    overflow |-> !byteValid);
endmodule

// File: rtl/vcd_cmd_decoder.sv
module vcd_cmd_decoder
  import vcd_pkg::*;
#(
  parameter int MaxLen     = 8,
  parameter int TsW        = 32,
  parameter int SyncStages = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rxSample,
  output logic                        byteValid,
  output logic [7:0]                  byteData,
  output logic                        frameDone,
  output logic [$clog2(MaxLen+1)-1:0] frameLen,
  output logic                        overflow,
  output logic                        codingMode,
  output logic [TsW-1:0]              eofTime,
  output logic [TsW-1:0]              sofTime
);
  logic    lineBit;
  logic    eofHit;
  dpCtrl_t ctrl;

  vcd_in_sync #(.Stages(SyncStages)) u_sync (
    .clk(clk), .rst(rst), .din(rxSample), .dout(lineBit)
  );

  vcd_frame_ctrl u_ctrl (
    .clk(clk), .rst(rst), .bitIn(lineBit), .eofHit(eofHit), .ctrl(ctrl)
  );

  vcd_slot_datapath #(.MaxLen(MaxLen), .TsW(TsW)) u_dp (
    .clk(clk), .rst(rst), .bitIn(lineBit), .ctrl(ctrl),
    .eofHit(eofHit), .byteValid(byteValid), .byteData(byteData),
    .frameDone(frameDone), .frameLen(frameLen), .overflow(overflow),
    .eofTime(eofTime), .sofTime(sofTime)
  );

  assign codingMode = ctrl.mode256;
endmodule

// File: tb/tb_vcd_cmd_decoder.sv
module tb_vcd_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxs = 1'b0;
  logic        byteValid, frameDone, overflow, codingMode;
  logic [7:0]  byteData;
  logic [3:0]  frameLen;
  logic [31:0] eofTime, sofTime;

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [7:0] gotB [0:1023];
  int gotN = 0, doneCnt = 0, ovCnt = 0;
  int lastLen = 0, lastMode = 0, lastObs = 0;
  longint lastEof = 0, lastSof = 0;
  logic [7:0] expB [0:15];
  bit finished = 0;

  vcd_cmd_decoder dut (
    .clk(clk), .rst(rst), .rxSample(rxs), .byteValid(byteValid),
    .byteData(byteData), .frameDone(frameDone), .frameLen(frameLen),
    .overflow(overflow), .codingMode(codingMode), .eofTime(eofTime),
    .sofTime(sofTime)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (byteValid && gotN < 1024) begin gotB[gotN] = byteData; gotN++; end
      if (frameDone) begin
        doneCnt++; lastLen = frameLen; lastMode = codingMode;
        lastEof = eofTime; lastSof = sofTime; lastObs = cyc;
      end
      if (overflow) ovCnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input bit b, input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); rxs = b; end
  endtask

  // slot: kind 0 = quiet, 1 = pulse, 2 = end-of-frame; bnd uses threshold sums
  task automatic slot(input int kind, input bit bnd);
    if (kind == 0) put(1, 8);
    else if (kind == 1) begin
      if (bnd) begin put(1, 3); put(0, 1); put(0, 3); put(1, 1); end
      else begin put(1, 4); put(0, 4); end
    end else begin
      if (bnd) begin put(1, 1); put(0, 3); put(0, 1); put(1, 3); end
      else begin put(0, 4); put(1, 4); end
    end
  endtask

  task automatic sendSof(input bit m256, input int l1, input int h1, input int l2);
    put(0, l1); put(1, h1); put(0, l2);
    put(1, m256 ? 1 : 9);
  endtask

  task automatic sendByte(input bit m256, input logic [7:0] b, input bit bnd);
    if (m256) begin
      for (int s = 0; s < 256; s++) slot((s == b) ? 1 : 0, bnd);
    end else begin
      for (int g = 0; g < 4; g++)
        for (int s = 0; s < 4; s++) slot((s == ((b >> (2*g)) & 3)) ? 1 : 0, bnd);
    end
  endtask

  task automatic runFrame(input bit m256, input int l1, input int h1, input int l2,
                          input bit bnd, input int n);
    put(1, 12);
    sendSof(m256, l1, h1, l2);
    for (int i = 0; i < n; i++) sendByte(m256, expB[i], bnd);
    slot(2, bnd);
    put(1, 8);
  endtask

  task automatic verifyFrame(input string req, input bit m256, input int n,
                             input int base, input int doneBefore);
    int bad = 0;
    chk(doneCnt == doneBefore + 1, req, "frame count", doneCnt, doneBefore + 1);
    chk(lastLen == n, req, "frameLen", lastLen, n);
    chk(lastMode == int'(m256), req, "codingMode", lastMode, m256);
    for (int i = 0; i < n; i++)
      if (base + i >= gotN || gotB[base + i] != expB[i]) begin
        bad++;
        if (base + i < gotN)
          $display("FAIL %s byte %0d actual=%0d expected=%0d", req, i, gotB[base+i], expB[i]);
      end
    chk(bad == 0 && gotN == base + n, req, "byte stream count", gotN - base, n);
    chk(lastEof == lastObs - 1, "R9", "eofTime", lastEof, lastObs - 1);
    chk(lastSof == lastEof - n * (m256 ? 2048 : 128) - 48, "R9", "sofTime",
        lastSof, lastEof - n * (m256 ? 2048 : 128) - 48);
  endtask

  task automatic goodAfter(input string req);
    int base = gotN, d = doneCnt;
    expB[0] = 8'h3C; expB[1] = 8'hC3;
    put(1, 40);
    runFrame(0, 4, 16, 4, 0, 2);
    verifyFrame(req, 0, 2, base, d);
  endtask

  initial begin
    repeat (40) @(posedge clk);
    if (!finished) begin end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int base, d, o;
    rxs = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!byteValid && !frameDone && !overflow, "R8", "reset pulses", 0, 0);
    chk(frameLen == 0 && codingMode == 0 && eofTime == 0 && sofTime == 0,
        "R9", "reset values", frameLen, 0);

    // R1: line low from reset, then an unprefixed low/high pattern
    put(0, 60);
    chk(gotN == 0 && doneCnt == 0 && ovCnt == 0, "R1", "activity without carrier", gotN, 0);
    goodAfter("R1");

    // R6 basic 1-out-of-4 frame
    base = gotN; d = doneCnt;
    expB[0] = 8'h00; expB[1] = 8'hFF; expB[2] = 8'hA5;
    runFrame(0, 4, 16, 4, 0, 3);
    verifyFrame("R6", 0, 3, base, d);

    // R6 sweep of all byte values, eight per frame
    for (int f = 0; f < 32; f++) begin
      base = gotN; d = doneCnt;
      for (int i = 0; i < 8; i++) expB[i] = 8'(f * 8 + i);
      runFrame(0, 4, 16, 4, 0, 8);
      verifyFrame("R6", 0, 8, base, d);
    end

    // R7 1-out-of-256 frames
    base = gotN; d = doneCnt;
    expB[0] = 8'h00; expB[1] = 8'hFF; expB[2] = 8'h5A; expB[3] = 8'h81;
    runFrame(1, 4, 24, 4, 0, 4);
    verifyFrame("R7", 1, 4, base, d);
    base = gotN; d = doneCnt;
    expB[0] = 8'h01; expB[1] = 8'hFE; expB[2] = 8'h80;
    runFrame(1, 4, 24, 4, 0, 3);
    verifyFrame("R7", 1, 3, base, d);

    // R5 threshold-shaped slots
    base = gotN; d = doneCnt;
    expB[0] = 8'h96; expB[1] = 8'h1E;
    runFrame(0, 4, 16, 4, 1, 2);
    verifyFrame("R5", 0, 2, base, d);

    // R2 boundary: rising edge at count 4 accepted
    base = gotN; d = doneCnt; expB[0] = 8'h42;
    runFrame(0, 3, 16, 4, 0, 1);
    verifyFrame("R2", 0, 1, base, d);
    // R3 boundaries of the 1-out-of-4 window and the 1-out-of-256 window
    base = gotN; d = doneCnt; expB[0] = 8'h24;
    runFrame(0, 4, 15, 4, 0, 1);
    verifyFrame("R3", 0, 1, base, d);
    base = gotN; d = doneCnt; expB[0] = 8'h99;
    runFrame(0, 4, 17, 4, 0, 1);
    verifyFrame("R3", 0, 1, base, d);
    base = gotN; d = doneCnt; expB[0] = 8'h77;
    runFrame(1, 4, 23, 4, 0, 1);
    verifyFrame("R3", 1, 1, base, d);
    // R4 boundaries of the second rising edge
    base = gotN; d = doneCnt; expB[0] = 8'hE7;
    runFrame(0, 4, 16, 3, 0, 1);
    verifyFrame("R4", 0, 1, base, d);
    base = gotN; d = doneCnt; expB[0] = 8'h10;
    runFrame(1, 4, 24, 3, 0, 1);
    verifyFrame("R4", 1, 1, base, d);

    // R2 too-early rising edge
    put(1, 12); put(0, 2); put(1, 16); put(0, 4);
    goodAfter("R2");
    // R3 second falling edge too early and between windows
    put(1, 12); put(0, 4); put(1, 13); put(0, 4);
    goodAfter("R3");
    put(1, 12); put(0, 4); put(1, 19); put(0, 4);
    goodAfter("R3");
    // R3 high level too long
    put(1, 12); put(0, 4); put(1, 40);
    goodAfter("R3");
    // R4 early second rise, both codings, and broken tail
    put(1, 12); put(0, 4); put(1, 16); put(0, 2);
    goodAfter("R4");
    put(1, 12); put(0, 4); put(1, 24); put(0, 2);
    goodAfter("R4");
    put(1, 12); put(0, 4); put(1, 16); put(0, 4); put(1, 4); put(0, 4);
    goodAfter("R4");

    // R8 end-of-frame with no byte
    base = gotN; d = doneCnt;
    runFrame(0, 4, 16, 4, 0, 0);
    chk(doneCnt == d && gotN == base, "R8", "empty frame reported", doneCnt - d, 0);
    goodAfter("R8");

    // R10 overflow: nine bytes with a limit of eight
    base = gotN; d = doneCnt; o = ovCnt;
    for (int i = 0; i < 9; i++) expB[i] = 8'(8'h11 * i);
    runFrame(0, 4, 16, 4, 0, 9);
    chk(ovCnt == o + 1, "R10", "overflow pulses", ovCnt - o, 1);
    chk(doneCnt == d, "R10", "overflowed frame reported", doneCnt - d, 0);
    chk(gotN == base + 8, "R10", "bytes delivered", gotN - base, 8);
    goodAfter("R10");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule